// File: doc/BRIEF.md
# 40-bit Saturating Multiply-Accumulate Accumulator

This block is the adder and accumulator stage of a multiply-accumulate datapath. On each enabled clock edge it adds two 40-bit operands and writes the sum into a 40-bit accumulator register. The first operand is picked from four sources: zero, a rounding constant, a sign-extended 32-bit product, or a sign-extended word formed from two 16-bit bus halves. The product and the bus word each have their own optional one-bit left shift. The second operand is zero or the accumulator fed back, with an optional one-bit left shift and an optional inversion. Inversion adds a carry-in of one, so the result is a true subtraction.

Eight guard bits above a 32-bit value absorb intermediate growth across a run of accumulations. An extension flag reports when those guard bits hold significant data. When automatic saturation is enabled, any result outside the signed 32-bit range is clamped to the largest positive or most negative 32-bit value, held sign-extended in 40 bits. Two sticky flags record saturation events and overflow of the full 40-bit range. Each stays set until its own clear input is pulsed. The product and bus words come from outside. Instruction decode and operand moves belong to the surrounding logic.

Top module: `mac_acc40`

## Requirements
- R1: `a_sel_i` selects the first operand: 0 gives zero, 1 gives the rounding constant 0x00_0000_8000, 2 gives the product path and 3 gives the bus path.
- R2: The product path sign-extends `prod_i` from 32 to 40 bits and, when `prod_shift_i` is 1, shifts it left by one bit.
- R3: The bus path sign-extends the 32-bit word {`bus_hi_i`,`bus_lo_i`} (high half in bits 31:16) to 40 bits and, when `bus_shift_i` is 1, shifts it left by one bit. This shift does not depend on `prod_shift_i`.
- R4: `b_sel_i`=0 gives a zero second operand and `b_sel_i`=1 gives the accumulator. When `b_shift_i` is 1 that value is shifted left by one bit within 40 bits. When `b_inv_i` is 1 it is inverted and a carry-in of 1 is added, so the accumulator result is A minus B.
- R5: While `en_i` is 0, the accumulator holds its value and neither sticky flag can be set.
- R6: With `sat_en_i`=1, a full-precision sum outside the signed 32-bit range loads 0x00_7FFF_FFFF if that sum is positive, or 0xFF_8000_0000 if it is negative. The sign is taken from the full-precision sum, even when the 40-bit result has wrapped.
- R7: With `sat_en_i`=0, the low 40 bits of the sum are stored unchanged, including after wraparound.
- R8: `sat_flag_o` is set by a saturating update and stays set until `clr_sat_i` is pulsed. If a saturating update and a clear occur in the same cycle, the flag ends up set.
- R9: `ovf_flag_o` is set by an enabled update whose sum overflows 40 bits: the two operands have the same bit 39 and the result's bit 39 differs. It stays set until `clr_ovf_i` is pulsed. If an overflow and a clear occur in the same cycle, the flag ends up set.
- R10: `ext_o` is 1 exactly when bits 39 to 31 of the accumulator are not all equal.
- R11: While `rst_ni` is low, the accumulator and both sticky flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Accumulator update enable |
| a_sel_i | input | 2 | First-operand source select |
| b_sel_i | input | 1 | Second operand: 0 zero, 1 accumulator |
| b_shift_i | input | 1 | Shift second operand left by one |
| b_inv_i | input | 1 | Invert second operand and add carry-in (subtract) |
| prod_i | input | 32 | Signed product word |
| prod_shift_i | input | 1 | Shift product left by one |
| bus_hi_i | input | 16 | Upper half of bus word |
| bus_lo_i | input | 16 | Lower half of bus word |
| bus_shift_i | input | 1 | Shift bus word left by one |
| sat_en_i | input | 1 | Enable automatic 32-bit saturation |
| clr_sat_i | input | 1 | Clear saturation sticky flag |
| clr_ovf_i | input | 1 | Clear 40-bit overflow sticky flag |
| acc_o | output | 40 | Accumulator value |
| ext_o | output | 1 | Guard bits hold significant data |
| sat_flag_o | output | 1 | Sticky saturation flag |
| ovf_flag_o | output | 1 | Sticky 40-bit overflow flag |

## Verification
Every accumulator and sticky-flag result appears one clock after the enabled edge that computes it. `ext_o` is decoded from the register without further delay, so it changes at that same edge. The bench drives each operation at a falling edge and samples at the next falling edge, which is half a period after the single rising edge in between. Clear pulses are applied with the enable low, and the bench confirms at that same sample point that the flag has dropped and the accumulator has not changed.

// File: rtl/mac_acc_pkg.sv
package mac_acc_pkg;
  typedef enum logic [1:0] {
    ASRC_ZERO = 2'd0,
    ASRC_RND  = 2'd1,
    ASRC_PROD = 2'd2,
    ASRC_BUS  = 2'd3
  } a_src_e;
endpackage

// File: rtl/mac_a_mux.sv
module mac_a_mux
  import mac_acc_pkg::*;
#(
  parameter int ACC_W   = 40,
  parameter int PROD_W  = 32,
  parameter int HALF_W  = 16,
  parameter int RND_BIT = 15
) (
  input  a_src_e              sel_i,
  input  logic [PROD_W-1:0]   prod_i,
  input  logic                prod_shift_i,
  input  logic [HALF_W-1:0]   bus_hi_i,
  input  logic [HALF_W-1:0]   bus_lo_i,
  input  logic                bus_shift_i,
  output logic [ACC_W-1:0]    a_o
);
  localparam int BUS_W = 2 * HALF_W;
  localparam int EXT_P = ACC_W - PROD_W;
  localparam int EXT_B = ACC_W - BUS_W;
  localparam logic [ACC_W-1:0] RND_VAL = {{(ACC_W-1){1'b0}}, 1'b1} << RND_BIT;

  logic [BUS_W-1:0] bus_word;
  logic [ACC_W-1:0] prod_ext, bus_ext, prod_op, bus_op;

  assign bus_word = {bus_hi_i, bus_lo_i};
  assign prod_ext = {{EXT_P{prod_i[PROD_W-1]}}, prod_i};
  assign bus_ext  = {{EXT_B{bus_word[BUS_W-1]}}, bus_word};
  // independent shift controls for the two sources
  assign prod_op  = prod_shift_i ? {prod_ext[ACC_W-2:0], 1'b0} : prod_ext;
  assign bus_op   = bus_shift_i  ? {bus_ext[ACC_W-2:0], 1'b0}  : bus_ext;

  always_comb begin
    unique case (sel_i)
      ASRC_ZERO: a_o = '0;
      ASRC_RND:  a_o = RND_VAL;
      ASRC_PROD: a_o = prod_op;
      default:   a_o = bus_op;
    endcase
  end
endmodule

// File: rtl/mac_b_path.sv
module mac_b_path #(
  parameter int ACC_W = 40
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic             sel_acc_i,
  input  logic             shift_i,
  input  logic             inv_i,
  output logic [ACC_W-1:0] b_o,
  output logic             cin_o
);
  logic [ACC_W-1:0] base, shifted;

  assign base    = sel_acc_i ? acc_i : '0;
  assign shifted = shift_i ? {base[ACC_W-2:0], 1'b0} : base;
  assign b_o     = inv_i ? ~shifted : shifted;
  // carry-in completes the two's complement negate
  assign cin_o   = inv_i;
endmodule

// File: rtl/mac_sum_sat.sv
module mac_sum_sat #(
  parameter int ACC_W = 40,
  parameter int SAT_W = 32
) (
  input  logic [ACC_W-1:0] a_i,
  input  logic [ACC_W-1:0] b_i,
  input  logic             cin_i,
  input  logic             sat_en_i,
  output logic [ACC_W-1:0] res_o,
  output logic             sat_hit_o,
  output logic             ovf_o
);
  localparam int FW = ACC_W + 1;
  localparam int HI_W = FW - SAT_W + 1;
  localparam logic [ACC_W-1:0] SAT_POS = {{(ACC_W-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] SAT_NEG = {{(ACC_W-SAT_W+1){1'b1}}, {(SAT_W-1){1'b0}}};

  logic [FW-1:0]   full;
  logic [HI_W-1:0] hi;
  logic            in_rng;

  // full-precision sum, one guard bit above the accumulator
  assign full   = {a_i[ACC_W-1], a_i} + {b_i[ACC_W-1], b_i} + {{ACC_W{1'b0}}, cin_i};
  assign ovf_o  = full[FW-1] ^ full[FW-2];
  assign hi     = full[FW-1:SAT_W-1];
  assign in_rng = (&hi) | ~(|hi);
  assign sat_hit_o = sat_en_i & ~in_rng;
  assign res_o  = sat_hit_o ? (full[FW-1] ? SAT_NEG : SAT_POS) : full[ACC_W-1:0];
endmodule

// File: rtl/mac_acc40.sv
module mac_acc40
  import mac_acc_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int PROD_W = 32,
  parameter int HALF_W = 16,
  parameter int SAT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [1:0]        a_sel_i,
  input  logic              b_sel_i,
  input  logic              b_shift_i,
  input  logic              b_inv_i,
  input  logic [PROD_W-1:0] prod_i,
  input  logic              prod_shift_i,
  input  logic [HALF_W-1:0] bus_hi_i,
  input  logic [HALF_W-1:0] bus_lo_i,
  input  logic              bus_shift_i,
  input  logic              sat_en_i,
  input  logic              clr_sat_i,
  input  logic              clr_ovf_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic              ext_o,
  output logic              sat_flag_o,
  output logic              ovf_flag_o
);
  localparam int GRD_W = ACC_W - SAT_W + 1;

  logic [ACC_W-1:0] acc_q, a_op, b_op, sum;
  logic             cin, sat_hit, ovf_hit, sat_q, ovf_q;
  logic [GRD_W-1:0] grd;

  mac_a_mux #(.ACC_W(ACC_W), .PROD_W(PROD_W), .HALF_W(HALF_W)) u_a_mux (
    .sel_i        (a_src_e'(a_sel_i)),
    .prod_i       (prod_i),
    .prod_shift_i (prod_shift_i),
    .bus_hi_i     (bus_hi_i),
    .bus_lo_i     (bus_lo_i),
    .bus_shift_i  (bus_shift_i),
    .a_o          (a_op)
  );

  mac_b_path #(.ACC_W(ACC_W)) u_b_path (
    .acc_i     (acc_q),
    .sel_acc_i (b_sel_i),
    .shift_i   (b_shift_i),
    .inv_i     (b_inv_i),
    .b_o       (b_op),
    .cin_o     (cin)
  );

  mac_sum_sat #(.ACC_W(ACC_W), .SAT_W(SAT_W)) u_sum (
    .a_i       (a_op),
    .b_i       (b_op),
    .cin_i     (cin),
    .sat_en_i  (sat_en_i),
    .res_o     (sum),
    .sat_hit_o (sat_hit),
    .ovf_o     (ovf_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      sat_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (en_i) acc_q <= sum;
      // a new event wins over a same-cycle clear
      sat_q <= (en_i & sat_hit) | (sat_q & ~clr_sat_i);
      ovf_q <= (en_i & ovf_hit) | (ovf_q & ~clr_ovf_i);
    end
  end

  assign grd        = acc_q[ACC_W-1:SAT_W-1];
  assign ext_o      = ~((&grd) | ~(|grd));
  assign acc_o      = acc_q;
  assign sat_flag_o = sat_q;
  assign ovf_flag_o = ovf_q;

  // R5
  hold_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_o));

  // R6
  sat_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sat_en_i) |=> !ext_o);

  // R8
  sat_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_flag_o && !clr_sat_i) |=> sat_flag_o);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_o && !clr_ovf_i) |=> ovf_flag_o);

  // R4
  feedback_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && a_sel_i == 2'd0 && b_sel_i && !b_shift_i && !b_inv_i && !sat_en_i)
      |=> $stable(acc_o));
endmodule

// File: tb/sim_mac_acc40.sv
module sim_mac_acc40;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  a_sel = '0;
  logic        b_sel = 1'b0, b_shift = 1'b0, b_inv = 1'b0;
  logic [31:0] prod = '0;
  logic        prod_sh = 1'b0;
  logic [15:0] bus_hi = '0, bus_lo = '0;
  logic        bus_sh = 1'b0, sat_en = 1'b0, clr_sat = 1'b0, clr_ovf = 1'b0;
  logic [39:0] acc;
  logic        ext, sat_f, ovf_f;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  mac_acc40 u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .a_sel_i(a_sel), .b_sel_i(b_sel),
    .b_shift_i(b_shift), .b_inv_i(b_inv), .prod_i(prod), .prod_shift_i(prod_sh),
    .bus_hi_i(bus_hi), .bus_lo_i(bus_lo), .bus_shift_i(bus_sh), .sat_en_i(sat_en),
    .clr_sat_i(clr_sat), .clr_ovf_i(clr_ovf), .acc_o(acc), .ext_o(ext),
    .sat_flag_o(sat_f), .ovf_flag_o(ovf_f)
  );

  task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive at falling edge, one rising edge, sample at next falling edge
  task automatic op(input logic [1:0] as, input logic bs, input logic bsh, input logic bi,
                    input logic [31:0] p, input logic psh, input logic [31:0] bw,
                    input logic bwsh, input logic se, input logic do_en);
    a_sel = as; b_sel = bs; b_shift = bsh; b_inv = bi;
    prod = p; prod_sh = psh; bus_hi = bw[31:16]; bus_lo = bw[15:0];
    bus_sh = bwsh; sat_en = se; en = do_en;
    @(negedge clk);
    en = 1'b0; clr_sat = 1'b0; clr_ovf = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 acc", acc, 40'h0);
    chk("R11 sat", {39'h0, sat_f}, 40'h0);
    chk("R11 ovf", {39'h0, ovf_f}, 40'h0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_sources;
    op(2'd1, 0, 0, 0, 32'h0, 0, 32'h0, 0, 0, 1);
    chk("R1 round", acc, 40'h00_0000_8000);
    op(2'd2, 0, 0, 0, 32'h8000_0000, 0, 32'h0, 0, 0, 1);
    chk("R2 prod sext", acc, 40'hFF_8000_0000);
    chk("R10 ext low", {39'h0, ext}, 40'h0);
    op(2'd2, 0, 0, 0, 32'h8000_0000, 1, 32'h0, 0, 0, 1);
    chk("R2 prod shift", acc, 40'hFF_0000_0000);
    chk("R10 ext high", {39'h0, ext}, 40'h1);
    op(2'd0, 0, 0, 0, 32'h8000_0000, 1, 32'h0, 0, 0, 1);
    chk("R1 zero", acc, 40'h0);
    op(2'd3, 0, 0, 0, 32'h0, 1, 32'h1234_5678, 0, 0, 1);
    chk("R3 bus no shift", acc, 40'h00_1234_5678);
    op(2'd3, 0, 0, 0, 32'h0, 0, 32'h1234_5678, 1, 0, 1);
    chk("R3 bus shift", acc, 40'h00_2468_ACF0);
  endtask

  task automatic t_bpath;
    op(2'd2, 1, 0, 0, 32'h10, 0, 32'h0, 0, 0, 1);
    chk("R4 add acc", acc, 40'h00_2468_AD00);
    op(2'd2, 1, 0, 1, 32'h10, 0, 32'h0, 0, 0, 1);
    chk("R4 subtract", acc, 40'hFF_DB97_5310);
    op(2'd0, 1, 1, 0, 32'h0, 0, 32'h0, 0, 0, 1);
    chk("R4 shift acc", acc, 40'hFF_B72E_A620);
    op(2'd0, 1, 0, 0, 32'h0, 0, 32'h0, 0, 0, 1);
    chk("R4 pass acc", acc, 40'hFF_B72E_A620);
    op(2'd3, 0, 0, 0, 32'h0, 0, 32'h0000_0055, 0, 0, 0);
    chk("R5 hold acc", acc, 40'hFF_B72E_A620);
  endtask

  task automatic t_sat;
    op(2'd3, 0, 0, 0, 32'h0, 0, 32'h7FFF_FFFF, 0, 0, 1);
    op(2'd3, 1, 0, 0, 32'h0, 0, 32'h0000_0001, 0, 0, 1);
    chk("R7 wrap past 32", acc, 40'h00_8000_0000);
    chk("R7 no sat flag", {39'h0, sat_f}, 40'h0);
    op(2'd3, 0, 0, 0, 32'h0, 0, 32'h7FFF_FFFF, 0, 1, 1);
    op(2'd3, 1, 0, 0, 32'h0, 0, 32'h0000_0001, 0, 1, 1);
    chk("R6 sat positive", acc, 40'h00_7FFF_FFFF);
    chk("R8 sat flag set", {39'h0, sat_f}, 40'h1);
    op(2'd3, 0, 0, 0, 32'h0, 0, 32'h8000_0000, 0, 1, 1);
    op(2'd3, 1, 0, 0, 32'h0, 0, 32'hFFFF_FFFF, 0, 1, 1);
    chk("R6 sat negative", acc, 40'hFF_8000_0000);
    chk("R8 sat flag sticky", {39'h0, sat_f}, 40'h1);
    clr_sat = 1'b1;
    op(2'd2, 0, 0, 0, 32'h1, 0, 32'h0, 0, 0, 0);
    chk("R8 sat flag cleared", {39'h0, sat_f}, 40'h0);
    chk("R8 clear keeps acc", acc, 40'hFF_8000_0000);
  endtask

  // acc = 0x7F_FFFF_FF00
  task automatic build_top;
    op(2'd3, 0, 0, 0, 32'h0, 0, 32'h7FFF_FFFF, 1, 0, 1);
    for (int i = 0; i < 7; i++) op(2'd0, 1, 1, 0, 32'h0, 0, 32'h0, 0, 0, 1);
  endtask

  task automatic t_ovf;
    build_top();
    chk("R4 repeated shift", acc, 40'h7F_FFFF_FF00);
    chk("R9 no ovf yet", {39'h0, ovf_f}, 40'h0);
    op(2'd2, 1, 0, 0, 32'h100, 0, 32'h0, 0, 0, 1);
    chk("R7 40-bit wrap", acc, 40'h80_0000_0000);
    chk("R9 ovf set", {39'h0, ovf_f}, 40'h1);
    op(2'd0, 0, 0, 0, 32'h0, 0, 32'h0, 0, 0, 1);
    chk("R9 ovf sticky", {39'h0, ovf_f}, 40'h1);
    clr_ovf = 1'b1;
    op(2'd0, 0, 0, 0, 32'h0, 0, 32'h0, 0, 0, 0);
    chk("R9 ovf cleared", {39'h0, ovf_f}, 40'h0);
    build_top();
    clr_ovf = 1'b1;
    clr_sat = 1'b1;
    op(2'd2, 1, 0, 0, 32'h100, 0, 32'h0, 0, 1, 1);
    chk("R6 sat uses full sign", acc, 40'h00_7FFF_FFFF);
    chk("R8 set wins over clear", {39'h0, sat_f}, 40'h1);
    chk("R9 set wins over clear", {39'h0, ovf_f}, 40'h1);
  endtask

  initial begin
    #4_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog act=running exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_sources();
    t_bpath();
    t_sat();
    t_ovf();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule